// File: doc/BRIEF.md
# CCD Pixel Stream Region Tagger

This block sits after a full-frame CCD readout sequencer and its converter. For every pixel strobe it receives the horizontal position, the line number and the digitized sample. It labels the pixel by where it falls in the horizontal layout of a line. The layout holds a short run of register-only dummy phases, then the photo-active columns, then a light-shielded reference run, then a few more dummy phases. Separately, it marks the shielded lines at the top and bottom of the frame. It drives an active-pixel valid that downstream image logic can use directly.

The block also maintains a per-line dark level for later offset removal. It averages only the shielded reference pixels that can be trusted. The two columns that border the photo-active region are dropped, as are the two lines read out first and every shielded border line. Because more charge drives the output voltage down, the sample can be bit-inverted before it is summed. The average divides by 14 with a reciprocal multiply and a right shift. The new level appears one clock after the last reference pixel of a line. It holds until the next line that qualifies.

Top module: `ccd_region_tagger`

## Requirements
- R1: One cycle after a strobe, `tag_vld` is 1 and `tag_region` encodes the strobed column: 0 for columns 0..3 (leading dummy), 1 for 4..1283 (active), 2 for 1284..1299 (dark reference), 3 for 1300 and above (trailing dummy). Without a strobe, `tag_vld` is 0 the next cycle.
- R2: `tag_dark_line` is 1 for a strobed pixel on lines 0, 1, 2, 1026 or 1027, and 0 on lines 3..1025.
- R3: `act_vld` is 1 the cycle after a strobe only when the column is active (tag 1) and the line is not a dark line. Leading dummies never raise it.
- R4: `tag_no_est` is 1 for a dark-reference pixel that is excluded from the estimate. These are columns 1284 and 1285, and any dark-reference pixel on line 0 or 1 or on a dark line. It is 0 for every other pixel.
- R5: With `invert_en` at 1, each sample is replaced by its bitwise complement (4095 - value) before it is summed.
- R6: On lines 3..1025, the 14 samples of columns 1286..1299 are summed as S. The cycle after column 1299 is strobed, `dark_upd` pulses for one cycle and `dark_level` becomes min(4095, (S*4681 + 32768) >> 16).
- R7: On lines 0, 1, 2, 1026 and 1027, reference pixels change neither `dark_level` nor the running sum, and `dark_upd` stays 0.
- R8: After reset, `tag_vld`, `act_vld`, `dark_upd` and `dark_level` are all 0.
- R9: Cycles without a strobe leave the running sum untouched, whatever `col`, `line` and `pix_data` carry.
- R10: The values on columns 1284 and 1285 have no effect on `dark_level`.
- R11: A strobe on column 0 clears the running sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_stb | input | 1 | One pixel sample is present this cycle |
| col | input | 11 | Horizontal position within the line |
| line | input | 11 | Line number within the frame |
| pix_data | input | 12 | Digitized sample |
| invert_en | input | 1 | Complement samples before summing |
| tag_vld | output | 1 | Tag outputs describe the previous-cycle strobe |
| tag_region | output | 2 | Column region code |
| tag_dark_line | output | 1 | Pixel lies on a shielded border line |
| tag_no_est | output | 1 | Reference pixel excluded from the estimate |
| act_vld | output | 1 | Usable photo-active pixel |
| dark_level | output | 12 | Latest dark-level estimate |
| dark_upd | output | 1 | One-cycle pulse when `dark_level` changes |

## Verification
Region decoding is probed at each boundary column on either side. Lines just inside and just outside both shielded bands are probed too, so an off-by-one in any limit moves a tag. The dark estimate runs on four patterns. A flat value with large numbers on the excluded columns shows whether those columns leak in. A ramp with idle cycles full of junk data separates summing on strobe from summing every cycle. An inverted run tests the complement path, and full-scale input tests the rounding at the top of the range. Runs on lines 0, 1 and 1026 must leave the level untouched.

// File: rtl/ccd_region_tagger.sv
module ccd_region_tagger #(
  parameter int DW        = 12,
  parameter int CW        = 11,
  parameter int LW        = 11,
  parameter int LEAD      = 4,
  parameter int ACTIVE    = 1280,
  parameter int DARK      = 16,
  parameter int DARK_SKIP = 2,
  parameter int LINES     = 1028,
  parameter int TOP_DARK  = 3,
  parameter int BOT_DARK  = 2,
  parameter int EDGE_LINES = 2,
  parameter int SH        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_stb,
  input  logic [CW-1:0] col,
  input  logic [LW-1:0] line,
  input  logic [DW-1:0] pix_data,
  input  logic          invert_en,
  output logic          tag_vld,
  output logic [1:0]    tag_region,
  output logic          tag_dark_line,
  output logic          tag_no_est,
  output logic          act_vld,
  output logic [DW-1:0] dark_level,
  output logic          dark_upd
);
  localparam int NUSE  = DARK - DARK_SKIP;
  localparam int ACC_W = DW + $clog2(DARK + 1);
  localparam int RECIP = ((1 << SH) + NUSE / 2) / NUSE;
  localparam int PW    = ACC_W + SH + 1;
  localparam int QW    = PW - SH;

  localparam logic [CW-1:0] C_ACT  = CW'(LEAD);
  localparam logic [CW-1:0] C_DARK = CW'(LEAD + ACTIVE);
  localparam logic [CW-1:0] C_USE  = CW'(LEAD + ACTIVE + DARK_SKIP);
  localparam logic [CW-1:0] C_TRL  = CW'(LEAD + ACTIVE + DARK);
  localparam logic [CW-1:0] C_LAST = CW'(LEAD + ACTIVE + DARK - 1);
  localparam logic [LW-1:0] L_TOP  = LW'(TOP_DARK);
  localparam logic [LW-1:0] L_BOT  = LW'(LINES - BOT_DARK);
  localparam logic [LW-1:0] L_EDGE = LW'(EDGE_LINES);

  logic [1:0]       rgn;
  logic             dline, est_line, use_px, last_px;
  logic [DW-1:0]    d;
  logic [ACC_W-1:0] acc, sum_nxt;
  logic [QW-1:0]    q;
  logic [DW-1:0]    level;

  always_comb begin
    if (col < C_ACT)       rgn = 2'd0;
    else if (col < C_DARK) rgn = 2'd1;
    else if (col < C_TRL)  rgn = 2'd2;
    else                   rgn = 2'd3;
  end

  assign dline    = (line < L_TOP) || (line >= L_BOT);
  assign est_line = !dline && (line >= L_EDGE);
  assign use_px   = (rgn == 2'd2) && (col >= C_USE) && est_line;
  assign last_px  = (col == C_LAST);
  assign d        = invert_en ? ~pix_data : pix_data;
  assign sum_nxt  = acc + ACC_W'(d);
  assign q        = QW'((PW'(sum_nxt) * PW'(RECIP) + PW'(1 << (SH - 1))) >> SH);
  assign level    = (|q[QW-1:DW]) ? {DW{1'b1}} : q[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_vld       <= 1'b0;
      tag_region    <= 2'd0;
      tag_dark_line <= 1'b0;
      tag_no_est    <= 1'b0;
      act_vld       <= 1'b0;
      dark_upd      <= 1'b0;
      dark_level    <= '0;
      acc           <= '0;
    end else begin
      tag_vld    <= pix_stb;
      act_vld    <= pix_stb && (rgn == 2'd1) && !dline;
      tag_no_est <= pix_stb && (rgn == 2'd2) && !use_px;
      dark_upd   <= pix_stb && use_px && last_px;
      if (pix_stb) begin
        tag_region    <= rgn;
        tag_dark_line <= dline;
        if (col == '0) acc <= '0;
        else if (use_px) acc <= last_px ? '0 : sum_nxt;
        if (use_px && last_px) dark_level <= level;
      end
    end
  end
endmodule

// File: rtl/ccd_region_tagger_chk.sv
module ccd_region_tagger_chk #(
  parameter int CW = 11,
  parameter int DW = 12,
  parameter int LAST_COL = 1299
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_stb,
  input logic [CW-1:0] col,
  input logic          tag_vld,
  input logic [1:0]    tag_region,
  input logic          tag_dark_line,
  input logic          tag_no_est,
  input logic          act_vld,
  input logic [DW-1:0] dark_level,
  input logic          dark_upd
);
  a_r1_tag_follows_stb: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb |=> tag_vld);
  a_r1_no_tag_without_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_stb |=> !tag_vld);
  a_r3_act_in_active_region: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld |-> (tag_vld && tag_region == 2'd1 && !tag_dark_line));
  a_r2_dark_line_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    tag_dark_line |-> !act_vld);
  a_r4_no_est_on_reference: assert property (@(posedge clk) disable iff (!rst_n)
    tag_no_est |-> (tag_vld && tag_region == 2'd2));
  a_r6_upd_after_last_col: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_stb && col == CW'(LAST_COL)) |=> !dark_upd);
  a_r7_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !dark_upd |-> $stable(dark_level));
endmodule

bind ccd_region_tagger ccd_region_tagger_chk #(
  .CW(CW), .DW(DW), .LAST_COL(LEAD + ACTIVE + DARK - 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .col(col),
  .tag_vld(tag_vld), .tag_region(tag_region), .tag_dark_line(tag_dark_line),
  .tag_no_est(tag_no_est), .act_vld(act_vld), .dark_level(dark_level),
  .dark_upd(dark_upd)
);

// File: tb/test_ccd_region_tagger.sv
module test_ccd_region_tagger;
  logic clk = 1'b0, rst_n = 1'b0, pix_stb = 1'b0, invert_en = 1'b0;
  logic [10:0] col = '0, line = '0;
  logic [11:0] pix_data = '0;
  logic tag_vld, tag_dark_line, tag_no_est, act_vld, dark_upd;
  logic [1:0] tag_region;
  logic [11:0] dark_level;
  int n_chk = 0, n_fail = 0;
  int exp_level = 0;

  always #4 clk = ~clk;

  ccd_region_tagger i_ccd_region_tagger (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .col(col), .line(line),
    .pix_data(pix_data), .invert_en(invert_en), .tag_vld(tag_vld),
    .tag_region(tag_region), .tag_dark_line(tag_dark_line),
    .tag_no_est(tag_no_est), .act_vld(act_vld), .dark_level(dark_level),
    .dark_upd(dark_upd));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pix(input int c, input int l, input int v);
    pix_stb = 1'b1; col = 11'(c); line = 11'(l); pix_data = 12'(v);
    @(negedge clk);
    pix_stb = 1'b0;
  endtask

  task automatic idle_junk();
    col = 11'd1290; line = 11'd500; pix_data = 12'hFFF;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(tag_vld == 0, "R8 tag_vld", tag_vld, 0);
    check(act_vld == 0, "R8 act_vld", act_vld, 0);
    check(dark_upd == 0, "R8 dark_upd", dark_upd, 0);
    check(dark_level == 0, "R8 dark_level", dark_level, 0);
  endtask

  task automatic t_columns();
    int cols[8] = '{0, 3, 4, 1283, 1284, 1299, 1300, 1303};
    int rg[8]   = '{0, 0, 1, 1, 2, 2, 3, 3};
    foreach (cols[i]) begin
      pix(cols[i], 500, 0);
      check(tag_vld == 1, "R1 tag_vld", tag_vld, 1);
      check(tag_region == 2'(rg[i]), "R1 region", tag_region, rg[i]);
      check(act_vld == (rg[i] == 1), "R3 act_vld", act_vld, rg[i] == 1);
    end
    @(negedge clk);
    check(tag_vld == 0, "R1 no strobe", tag_vld, 0);
  endtask

  task automatic t_dark_lines();
    int ls[7] = '{0, 1, 2, 3, 1025, 1026, 1027};
    int dk[7] = '{1, 1, 1, 0, 0, 1, 1};
    foreach (ls[i]) begin
      pix(100, ls[i], 0);
      check(tag_dark_line == dk[i][0], "R2 dark line", tag_dark_line, dk[i]);
      check(act_vld == !dk[i][0], "R3 act on line", act_vld, !dk[i][0]);
    end
  endtask

  task automatic t_no_est();
    pix(1284, 500, 0); check(tag_no_est == 1, "R4 col1284", tag_no_est, 1);
    pix(1285, 500, 0); check(tag_no_est == 1, "R4 col1285", tag_no_est, 1);
    pix(1286, 500, 0); check(tag_no_est == 0, "R4 col1286", tag_no_est, 0);
    pix(1290, 1, 0);   check(tag_no_est == 1, "R4 line1", tag_no_est, 1);
    pix(1290, 2, 0);   check(tag_no_est == 1, "R4 dark line2", tag_no_est, 1);
    pix(1290, 1026, 0); check(tag_no_est == 1, "R4 line1026", tag_no_est, 1);
    pix(600, 500, 0);  check(tag_no_est == 0, "R4 active", tag_no_est, 0);
    pix(1301, 500, 0); check(tag_no_est == 0, "R4 trailing", tag_no_est, 0);
  endtask

  task automatic run_ref(input int l, input bit inv, input int vals[16],
                         input bit gaps, input bit counts, input string req);
    int s = 0;
    longint p;
    invert_en = inv;
    pix(0, l, 0);
    for (int k = 0; k < 16; k++) begin
      pix(1284 + k, l, vals[k]);
      if (k >= 2) s += inv ? (4095 - vals[k]) : vals[k];
      if (gaps && k < 15) idle_junk();
    end
    if (counts) begin
      p = longint'(s) * 4681 + 32768;
      exp_level = int'(p >>> 16);
      if (exp_level > 4095) exp_level = 4095;
      check(dark_upd == 1, {req, " upd pulse"}, dark_upd, 1);
    end else begin
      check(dark_upd == 0, {req, " no upd"}, dark_upd, 0);
    end
    check(dark_level == 12'(exp_level), {req, " level"}, dark_level, exp_level);
    @(negedge clk);
    check(dark_upd == 0, {req, " pulse ends"}, dark_upd, 0);
    check(dark_level == 12'(exp_level), {req, " level held"}, dark_level, exp_level);
    invert_en = 1'b0;
  endtask

  task automatic t_flat();
    int v[16];
    foreach (v[i]) v[i] = (i < 2) ? 4000 : 100;
    run_ref(10, 0, v, 0, 1, "R6 R10 flat");
  endtask

  task automatic t_ramp_gaps();
    int v[16];
    foreach (v[i]) v[i] = 50 * i + 7;
    run_ref(700, 0, v, 1, 1, "R9 R6 ramp");
  endtask

  task automatic t_invert();
    int v[16];
    foreach (v[i]) v[i] = 3000 + 13 * i;
    run_ref(400, 1, v, 0, 1, "R5 invert");
  endtask

  task automatic t_full();
    int v[16];
    foreach (v[i]) v[i] = 4095;
    run_ref(1025, 0, v, 0, 1, "R6 full scale");
  endtask

  task automatic t_excluded_lines();
    int v[16];
    foreach (v[i]) v[i] = 2222;
    run_ref(0, 0, v, 0, 0, "R7 line0");
    run_ref(1, 0, v, 0, 0, "R7 line1");
    run_ref(1026, 0, v, 0, 0, "R7 line1026");
  endtask

  task automatic t_clear();
    int v[16];
    int s = 0;
    longint p;
    invert_en = 1'b0;
    for (int k = 2; k < 8; k++) pix(1284 + k, 300, 900);
    pix(0, 300, 0);
    for (int k = 0; k < 16; k++) begin
      v[k] = 200 + k;
      pix(1284 + k, 300, v[k]);
      if (k >= 2) s += v[k];
    end
    p = longint'(s) * 4681 + 32768;
    exp_level = int'(p >>> 16);
    check(dark_level == 12'(exp_level), "R11 clear on col0", dark_level, exp_level);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_columns();
    t_dark_lines();
    t_no_est();
    t_flat();
    t_ramp_gaps();
    t_invert();
    t_excluded_lines();
    t_full();
    t_clear();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule